// File: doc/BRIEF.md
# Redundant Reference Clock Switchover

This block takes two reference clocks and delivers one of them on a single output clock. A static strap input names the preferred source. A supervisor on a free-running system clock watches both references for activity. When the preferred source goes quiet, the output moves to the other reference. Neither the outgoing nor the incoming clock can then leave a shortened high or low phase on the output.

A preferred source that has failed and then resumes is not trusted at once. The supervisor counts its rising edges and hands back only after a fixed number of them has been seen without a further dropout. A change of the strap while both references are running uses the same clean handover but skips this hold-off. The active source is reported on a status pin, and every completed changeover is marked with a one-cycle pulse in the system clock domain.

The handover gates each reference with an enable that is retimed on that reference's own falling edges. The old enable must be seen low back in the system domain before the new one is requested. A reference that has died is cleared asynchronously, so the handover cannot stall waiting for an edge that will never arrive. At integration the strap is tied high when left unused, which makes reference A preferred.

Top module: `rclk_switch`

## Requirements
- R1: `pri_a_i` high makes reference A preferred and low makes reference B preferred. `active_src_o` reads 0 while A drives `clk_o` and 1 while B drives it.
- R2: During and right after reset `active_src_o` is 0 and `switch_event_o` is 0.
- R3: A reference that shows no rising edge for `LOSS_CYC` (16) system cycles is declared lost. If it is the active source, the output moves to the other reference within 1.5 us in the default timing of the bench.
- R4: `clk_o` never carries a high or low phase shorter than the shorter half-period of the two references. The two per-source enables are never high at the same time.
- R5: A preferred reference that has been lost and then resumes becomes active again only after `QUAL_EDGES` (1024) of its rising edges have been seen. It is still inactive after 1000 of them.
- R6: A loss of the resuming preferred reference during qualification restarts its edge count from zero.
- R7: A change of `pri_a_i` while both references are running moves the output to the newly preferred reference without waiting out the qualification count.
- R8: `switch_event_o` is a one-cycle pulse. It is high exactly in the system cycle where `active_src_o` changes, once per change.
- R9: Once settled, `clk_o` has the period of the reference named by `active_src_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk_i | input | 1 | Free-running supervisor clock, faster than twice either reference |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_a_i | input | 1 | Reference clock A |
| ref_b_i | input | 1 | Reference clock B |
| pri_a_i | input | 1 | Preference strap: 1 prefers A, 0 prefers B |
| clk_o | output | 1 | Gated output clock taken from the active reference |
| active_src_o | output | 1 | Active reference: 0 = A, 1 = B |
| switch_event_o | output | 1 | One-cycle pulse, system domain, on each changeover |

## Verification
The bench drives A and B at different periods, 80 ns and 120 ns, so the measured output period identifies the source directly. It runs both references healthy, then the preferred one stopped, resumed, and dropped again partway through qualification. These patterns separate failover, the hold-off count and its restart. Strap flips with both clocks alive separate the handover without hold-off from the revert path. The whole sequence is then repeated with B as the preferred reference. A phase-width monitor that runs throughout catches any runt pulse at any of these changeovers.

// File: rtl/rclk_pkg.sv
package rclk_pkg;
  localparam int unsigned NSRC = 2;
  localparam logic SRC_A = 1'b0;
  localparam logic SRC_B = 1'b1;

  typedef enum logic [1:0] {
    HS_RUN   = 2'd0,
    HS_DROP  = 2'd1,
    HS_RAISE = 2'd2
  } hand_st_e;
endpackage

// File: rtl/rclk_act_mon.sv
module rclk_act_mon #(
  parameter int unsigned LOSS_CYC    = 16,
  parameter int unsigned QUAL_EDGES  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic sys_clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic alive_o,
  output logic qual_o
);
  localparam int unsigned SW = $clog2(LOSS_CYC + 1);
  localparam int unsigned QW = (QUAL_EDGES > 1) ? $clog2(QUAL_EDGES) : 1;
  localparam logic [SW-1:0] SIL_MAX  = SW'(LOSS_CYC);
  localparam logic [QW-1:0] QCNT_TOP = QW'(QUAL_EDGES - 1);

  logic [SYNC_STAGES:0] smp_q;
  logic                 rise;
  logic [SW-1:0]        sil_q;
  logic [QW-1:0]        qcnt_q;
  logic                 qual_q;

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= '0;
    else         smp_q <= {smp_q[SYNC_STAGES-1:0], ref_i};
  end

  assign rise = smp_q[SYNC_STAGES-1] & ~smp_q[SYNC_STAGES];

  // silence timer saturates at the loss limit
  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni)              sil_q <= '0;
    else if (rise)            sil_q <= '0;
    else if (sil_q != SIL_MAX) sil_q <= sil_q + 1'b1;
  end

  assign alive_o = (sil_q != SIL_MAX);

  // qualification: cleared on loss, set after QUAL_EDGES edges
  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qcnt_q <= '0;
      qual_q <= 1'b1;
    end else if (!alive_o && !rise) begin
      qcnt_q <= '0;
      qual_q <= 1'b0;
    end else if (rise && !qual_q) begin
      if (qcnt_q == QCNT_TOP) begin
        qcnt_q <= '0;
        qual_q <= 1'b1;
      end else begin
        qcnt_q <= qcnt_q + 1'b1;
      end
    end
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/rclk_gate.sv
module rclk_gate #(
  parameter int unsigned STAGES = 2
) (
  input  logic ref_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic req_i,
  output logic en_o
);
  logic              clr_n;
  logic [STAGES-1:0] en_q;

  assign clr_n = rst_ni & ~kill_i;

  // retimed on the falling edge so the gate opens and closes while ref is low
  always_ff @(negedge ref_i or negedge clr_n) begin
    if (!clr_n) en_q <= '0;
    else        en_q <= {en_q[STAGES-2:0], req_i};
  end

  assign en_o = en_q[STAGES-1];
endmodule

// File: rtl/rclk_ctl.sv
module rclk_ctl
  import rclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            sys_clk_i,
  input  logic            rst_ni,
  input  logic            pri_a_i,
  input  logic [NSRC-1:0] alive_i,
  input  logic [NSRC-1:0] qual_i,
  input  logic [NSRC-1:0] en_i,
  output logic [NSRC-1:0] req_o,
  output logic [NSRC-1:0] kill_o,
  output logic            active_o,
  output logic            switch_event_o
);
  logic [SYNC_STAGES-1:0]           pri_q;
  logic [SYNC_STAGES-1:0][NSRC-1:0] ack_q;
  logic [NSRC-1:0]                  ack;
  logic                             pri_idx, alt_idx, want;

  hand_st_e        st_q;
  logic            active_q, tgt_q, evt_q;
  logic [NSRC-1:0] req_q, kill_q;

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q <= '1;
      ack_q <= '0;
    end else begin
      pri_q <= {pri_q[SYNC_STAGES-2:0], pri_a_i};
      ack_q <= {ack_q[SYNC_STAGES-2:0], en_i};
    end
  end

  assign ack     = ack_q[SYNC_STAGES-1];
  assign pri_idx = pri_q[SYNC_STAGES-1] ? SRC_A : SRC_B;
  assign alt_idx = ~pri_idx;

  always_comb begin
    want = active_q;
    if (alive_i[pri_idx] && qual_i[pri_idx]) want = pri_idx;
    else if (alive_i[alt_idx])               want = alt_idx;
  end

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= HS_RUN;
      active_q <= SRC_A;
      tgt_q    <= SRC_A;
      req_q    <= 2'b01;
      kill_q   <= '0;
      evt_q    <= 1'b0;
    end else begin
      evt_q  <= 1'b0;
      kill_q <= ~req_q & ~alive_i;
      unique case (st_q)
        HS_RUN: begin
          if (want != active_q) begin
            req_q[active_q] <= 1'b0;
            tgt_q           <= want;
            st_q            <= HS_DROP;
          end
        end
        HS_DROP: begin
          if (!ack[active_q]) begin
            req_q[tgt_q] <= 1'b1;
            st_q         <= HS_RAISE;
          end
        end
        HS_RAISE: begin
          // a dead target cannot ack; hand over anyway so RUN can move on
          if (ack[tgt_q] || !alive_i[tgt_q]) begin
            active_q <= tgt_q;
            evt_q    <= 1'b1;
            st_q     <= HS_RUN;
          end
        end
        default: st_q <= HS_RUN;
      endcase
    end
  end

  assign req_o          = req_q;
  assign kill_o         = kill_q;
  assign active_o       = active_q;
  assign switch_event_o = evt_q;
endmodule

// File: rtl/rclk_switch.sv
module rclk_switch
  import rclk_pkg::*;
#(
  parameter int unsigned LOSS_CYC    = 16,
  parameter int unsigned QUAL_EDGES  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic sys_clk_i,
  input  logic rst_ni,
  input  logic ref_a_i,
  input  logic ref_b_i,
  input  logic pri_a_i,
  output logic clk_o,
  output logic active_src_o,
  output logic switch_event_o
);
  logic [NSRC-1:0] ref_v, alive, qual, gate_en, req, kill;

  assign ref_v = {ref_b_i, ref_a_i};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    rclk_act_mon #(
      .LOSS_CYC   (LOSS_CYC),
      .QUAL_EDGES (QUAL_EDGES),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
      .sys_clk_i(sys_clk_i),
      .rst_ni   (rst_ni),
      .ref_i    (ref_v[i]),
      .alive_o  (alive[i]),
      .qual_o   (qual[i])
    );

    rclk_gate #(
      .STAGES(SYNC_STAGES)
    ) u_gate (
      .ref_i (ref_v[i]),
      .rst_ni(rst_ni),
      .kill_i(kill[i]),
      .req_i (req[i]),
      .en_o  (gate_en[i])
    );
  end

  rclk_ctl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctl (
    .sys_clk_i     (sys_clk_i),
    .rst_ni        (rst_ni),
    .pri_a_i       (pri_a_i),
    .alive_i       (alive),
    .qual_i        (qual),
    .en_i          (gate_en),
    .req_o         (req),
    .kill_o        (kill),
    .active_o      (active_src_o),
    .switch_event_o(switch_event_o)
  );

  assign clk_o = |(ref_v & gate_en);
endmodule

// File: rtl/rclk_switch_chk.sv
module rclk_switch_chk (
  input logic       sys_clk_i,
  input logic       rst_ni,
  input logic [1:0] en_i,
  input logic [1:0] req_i,
  input logic       active_src_o,
  input logic       switch_event_o
);
  // R4
  excl_en_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    $onehot0(en_i));

  // R4
  excl_req_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    $onehot0(req_i));

  // R8
  event_change_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    switch_event_o |-> (active_src_o != $past(active_src_o)));

  // R8
  change_event_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (active_src_o != $past(active_src_o)) |-> switch_event_o);

  // R8
  event_pulse_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    switch_event_o |=> !switch_event_o);
endmodule

bind rclk_switch rclk_switch_chk u_chk (
  .sys_clk_i     (sys_clk_i),
  .rst_ni        (rst_ni),
  .en_i          (gate_en),
  .req_i         (req),
  .active_src_o  (active_src_o),
  .switch_event_o(switch_event_o)
);

// File: tb/rclk_switch_bench.sv
module rclk_switch_bench;
  localparam int SYS_PERIOD = 10;
  localparam int A_HALF     = 40;
  localparam int B_HALF     = 60;
  localparam int MIN_PHASE  = 35;
  localparam int WATCHDOG   = 150000;

  logic sys_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic ref_a   = 1'b0;
  logic ref_b   = 1'b0;
  logic pri_a   = 1'b1;
  logic run_a   = 1'b1;
  logic run_b   = 1'b1;
  logic clk_o, active, evt;

  int  n_chk = 0, n_fail = 0, ev_cnt = 0, short_cnt = 0;
  time last_edge = 0;
  bit  done = 1'b0;

  rclk_switch u_rclk_switch (
    .sys_clk_i     (sys_clk),
    .rst_ni        (rst_n),
    .ref_a_i       (ref_a),
    .ref_b_i       (ref_b),
    .pri_a_i       (pri_a),
    .clk_o         (clk_o),
    .active_src_o  (active),
    .switch_event_o(evt)
  );

  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;

  // stopped references always finish their high phase and rest low
  initial forever begin #(A_HALF); if (run_a || ref_a) ref_a = ~ref_a; end
  initial forever begin #(B_HALF); if (run_b || ref_b) ref_b = ~ref_b; end

  always @(negedge sys_clk) if (rst_n && evt) ev_cnt++;

  always @(clk_o) begin
    if ($time > 100 && ($time - last_edge) < MIN_PHASE) short_cnt++;
    last_edge = $time;
  end

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_active(input string req, input logic exp);
    check(req, active === exp, longint'(active), longint'(exp));
  endtask

  task automatic chk_events(input string req, input int exp);
    check(req, ev_cnt == exp, ev_cnt, exp);
  endtask

  task automatic chk_period(input string req, input int exp);
    time t0;
    @(posedge clk_o); t0 = $time;
    @(posedge clk_o);
    check(req, ($time - t0) == exp, longint'($time - t0), exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(SYS_PERIOD * WATCHDOG);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    repeat (5) @(posedge sys_clk);
    #2;
    // R2: reset state
    chk_active("R2", 1'b0);
    check("R2", evt === 1'b0, longint'(evt), 0);
    rst_n = 1'b1;

    #3000;
    chk_active("R1", 1'b0);
    chk_period("R9", 2*A_HALF);
    chk_events("R2", 0);

    // R3: preferred A fails
    run_a = 1'b0;
    #1500;
    chk_active("R3", 1'b1);
    chk_events("R8", 1);
    chk_period("R9", 2*B_HALF);

    // R5: A resumes, hold-off
    run_a = 1'b1;
    repeat (1000) @(posedge ref_a);
    #1;
    chk_active("R5", 1'b1);
    repeat (60) @(posedge ref_a);
    #1;
    chk_active("R5", 1'b0);
    chk_events("R8", 2);
    chk_period("R9", 2*A_HALF);

    // R6: dropout during qualification restarts count
    run_a = 1'b0;
    #1500;
    chk_active("R3", 1'b1);
    run_a = 1'b1;
    repeat (800) @(posedge ref_a);
    run_a = 1'b0;
    #400;
    run_a = 1'b1;
    repeat (800) @(posedge ref_a);
    #1;
    chk_active("R6", 1'b1);
    repeat (300) @(posedge ref_a);
    #1;
    chk_active("R6", 1'b0);
    chk_events("R8", 4);

    // R7: strap change with both healthy, no hold-off
    pri_a = 1'b0;
    #1500;
    chk_active("R7", 1'b1);
    chk_period("R1", 2*B_HALF);
    pri_a = 1'b1;
    #1500;
    chk_active("R7", 1'b0);
    chk_events("R8", 6);

    // R1: B preferred, then B fails and resumes
    pri_a = 1'b0;
    #1500;
    chk_active("R1", 1'b1);
    run_b = 1'b0;
    #1500;
    chk_active("R3", 1'b0);
    chk_period("R9", 2*A_HALF);
    run_b = 1'b1;
    repeat (1000) @(posedge ref_b);
    #1;
    chk_active("R5", 1'b0);
    repeat (60) @(posedge ref_b);
    #1;
    chk_active("R5", 1'b1);
    chk_events("R8", 9);

    // R4: no runt phase on the output over the whole run
    check("R4", short_cnt == 0, short_cnt, 0);
    finish_run();
  end
endmodule